// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block keeps a programmable SDRAM mode word and, for every READ or WRITE start, produces the column addresses the memory would access, one per clock. A 13-bit address-bus value written with a load strobe programs the word. The block decodes four settings from it: burst length (1, 2, 4, 8 or the whole page), sequential or interleaved ordering, a CAS latency of 2 or 3, and whether writes are forced to a single location. A fixed-length burst walks the low column bits inside an aligned block the size of the burst, and the upper bits stay fixed. A full-page burst walks all 256 columns in sequential order, wraps at the page end, and stops only when the terminate input is asserted. For read addresses, a read-valid flag follows each address by the CAS latency.

The control is a three-state machine. IDLE waits for a start. BURST runs a fixed-length burst. PAGE runs a full-page burst. The transitions are:
- start: from any state to BURST for a burst longer than one address, to PAGE for a full-page burst, or to IDLE for a single address. A start always begins a new sequence, so a start during a burst cuts the old burst short.
- last: from BURST to IDLE on the edge that issues the final address of the block.
- stop: from BURST or PAGE to IDLE when the terminate input is high and no start is present.
- hold: every other case keeps the current state.

The block is used next to an SDRAM command generator. That generator issues the start together with the starting column, then takes `col_addr`, `col_valid` and `rd_valid` to steer its column and data timing.

Top module: `sdram_col_seq`

## Requirements
- R1: Reset clears `col_valid`, `busy`, `rd_valid` and `mode_err` and sets the mode to length 1, sequential, CAS latency 2, burst writes. With no load, a start issues one address and `rd_valid` rises 2 cycles after it.
- R2: Mode word fields:
  - bits 2:0 give the length: 000=1, 001=2, 010=4, 011=8, 111=full page.
  - bit 3 gives the order: 0 sequential, 1 interleaved.
  - bits 6:4 give the CAS latency: 010=2, 011=3.
  - bits 8:7 must be 00.
  - bit 9 set makes writes single-location.
  - bits 12:10 have no effect.
- R3: Some loads are illegal: a length code of 100, 101 or 110; code 111 with bit 3 set; a CAS latency code other than 010 or 011; nonzero bits 8:7; or any load while `busy` is high. An illegal load leaves the mode unchanged and sets `mode_err`, which stays high until reset.
- R4: A start at a clock edge puts `start_col` on `col_addr` with `col_valid` high in the following cycle. In sequential order, address n of a length-L burst keeps the bits above log2(L) of the start column and has low bits equal to (start low bits + n) mod L.
- R5: In interleaved order, the low log2(L) bits of address n are the start's low bits XOR n.
- R6: A fixed-length burst issues exactly L consecutive addresses, and then `col_valid` falls. `busy` is high on every address except the last.
- R7: A full-page burst counts up through the columns, wraps from 255 to 0, and runs until `burst_stop` is sampled high. From the next cycle, `col_valid` and `busy` are low.
- R8: With mode bit 9 set, a write start issues one address with `busy` low, while reads keep the programmed length. `col_write` marks addresses that belong to a write burst.
- R9: A start during a burst abandons the old burst and begins the new sequence in the next cycle.
- R10: `rd_valid` is high exactly CAS-latency cycles after each cycle that carried a read address. The latency is the one in force when that burst started. Write addresses never raise `rd_valid`.
- R11: `burst_stop` while no burst runs has no effect. A start and a `burst_stop` in the same cycle behave as a start alone. A load in the same cycle as a start takes effect only from the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 13 | Address-bus value to load |
| cmd_start | input | 1 | READ or WRITE burst start |
| cmd_write | input | 1 | 1 for WRITE, 0 for READ, sampled with `cmd_start` |
| start_col | input | 8 | Starting column, sampled with `cmd_start` |
| burst_stop | input | 1 | Burst terminate |
| col_addr | output | 8 | Column address being accessed |
| col_valid | output | 1 | `col_addr` is valid this cycle |
| col_write | output | 1 | Current address belongs to a write burst |
| busy | output | 1 | More addresses follow in this burst |
| rd_valid | output | 1 | Read data due this cycle |
| mode_err | output | 1 | Sticky illegal-load flag |

## Verification
Starting columns are chosen so that the low bits sit mid-block (0x1E, 0x45, 0x33). This makes wrap-around inside the block visible and shows apart sequential addition, XOR ordering and leakage into the upper column bits. A full-page run from 0xFC separates a page-wide wrap from a block-sized one. The same write start is issued with the single-location bit set and cleared, which isolates that bit's effect on writes from reads. Back-to-back starts of different types, a terminate that coincides with a start, and a run of illegal loads followed by an observable burst tell truncation, priority and mode retention apart. The CAS latency changes between bursts so that `rd_valid` timing is seen for both latencies.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] len_log2;
        logic       full_page;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       wr_single;
    } mode_cfg_t;

endpackage

// File: rtl/sdram_col_mode.sv
module sdram_col_mode
    import sdram_col_pkg::*;
#(
    parameter int MODE_W = 13,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    input  logic              busy,
    output mode_cfg_t         cfg,
    output logic              err
);
    localparam int RSV_LO = 10;

    logic [2:0] len_code;
    logic       order_bit;
    logic [2:0] cl_code;
    logic [1:0] op_code;
    logic       len_ok;
    logic       cl_ok;
    logic       legal;

    always_comb begin
        len_code  = word[2:0];
        order_bit = word[3];
        cl_code   = word[6:4];
        op_code   = word[8:7];
        len_ok    = (len_code[2] == 1'b0) || ((len_code == 3'b111) && !order_bit);
        cl_ok     = (int'(cl_code) >= MIN_CL) && (int'(cl_code) <= MAX_CL);
        legal     = len_ok && cl_ok && (op_code == 2'b00) && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.len_log2   <= 2'd0;
            cfg.full_page  <= 1'b0;
            cfg.interleave <= 1'b0;
            cfg.cas_lat    <= 3'(MIN_CL);
            cfg.wr_single  <= 1'b0;
            err            <= 1'b0;
        end else if (load) begin
            if (legal) begin
                cfg.len_log2   <= len_code[1:0];
                cfg.full_page  <= (len_code == 3'b111);
                cfg.interleave <= order_bit;
                cfg.cas_lat    <= cl_code;
                cfg.wr_single  <= word[9];
            end else begin
                err <= 1'b1;
            end
        end
    end

    p_busy_load_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy) |=> ($stable(cfg) && err));

    p_rsv_len_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[2] && !(&word[2:0])) |=> ($stable(cfg) && err));

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_rsv_bits_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy && (word[6:4] == 3'b011) && (word[8:7] == 2'b00) && !word[2]
         && (|word[MODE_W-1:RSV_LO])) |=> (cfg.cas_lat == 3'd3));

endmodule

// File: rtl/sdram_col_step.sv
module sdram_col_step #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] low;

    always_comb begin
        if (interleave) begin
            low = base ^ cnt;
        end else begin
            low = base + cnt;
        end
        addr = (base & ~mask) | (low & mask);
    end

endmodule

// File: rtl/sdram_col_rdpipe.sv
module sdram_col_rdpipe #(
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [2:0] lat_sel,
    output logic       rd_valid
);
    logic [MAX_CL:MIN_CL] tail;

    for (genvar lat = MIN_CL; lat <= MAX_CL; lat++) begin : g_lat
        logic [lat-1:0] sh;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh <= {sh[lat-2:0], issue && (lat_sel == 3'(lat))};
            end
        end

        assign tail[lat] = sh[lat-1];

        p_lat_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
            sh[lat-1] |-> $past(issue && (lat_sel == 3'(lat)), lat));
    end

    assign rd_valid = |tail;

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_col_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 13,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_write,
    output logic              busy,
    output logic              rd_valid,
    output logic              mode_err
);
    localparam int MIN_CL = 2;

    seq_state_e       state;
    seq_state_e       nstate;
    mode_cfg_t        cfg;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic [COL_W-1:0] cnt_q;
    logic             ilv_q;
    logic [2:0]       cl_q;
    logic [COL_W-1:0] step_addr;

    logic             start_single;
    logic             start_page;
    logic [COL_W-1:0] start_mask;

    assign busy = (state != ST_IDLE);

    sdram_col_mode #(
        .MODE_W (MODE_W),
        .MIN_CL (MIN_CL),
        .MAX_CL (MAX_CL)
    ) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .busy  (busy),
        .cfg   (cfg),
        .err   (mode_err)
    );

    sdram_col_step #(
        .COL_W (COL_W)
    ) u_step (
        .base       (base_q),
        .cnt        (cnt_q),
        .mask       (mask_q),
        .interleave (ilv_q),
        .addr       (step_addr)
    );

    sdram_col_rdpipe #(
        .MIN_CL (MIN_CL),
        .MAX_CL (MAX_CL)
    ) u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (col_valid && !col_write),
        .lat_sel  (cl_q),
        .rd_valid (rd_valid)
    );

    always_comb begin
        start_single = cmd_write && cfg.wr_single;
        start_page   = cfg.full_page && !start_single;
        if (start_single) begin
            start_mask = '0;
        end else if (cfg.full_page) begin
            start_mask = '1;
        end else begin
            start_mask = COL_W'((1 << cfg.len_log2) - 1);
        end
    end

    always_comb begin
        nstate = state;
        if (cmd_start) begin
            if (start_page) begin
                nstate = ST_PAGE;
            end else if (start_mask != '0) begin
                nstate = ST_BURST;
            end else begin
                nstate = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_IDLE:  nstate = ST_IDLE;
                ST_BURST: nstate = (burst_stop || (cnt_q == mask_q)) ? ST_IDLE : ST_BURST;
                ST_PAGE:  nstate = burst_stop ? ST_IDLE : ST_PAGE;
                default:  nstate = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            mask_q    <= '0;
            cnt_q     <= '0;
            ilv_q     <= 1'b0;
            cl_q      <= 3'(MIN_CL);
            col_addr  <= '0;
            col_valid <= 1'b0;
            col_write <= 1'b0;
        end else if (cmd_start) begin
            base_q    <= start_col;
            mask_q    <= start_mask;
            cnt_q     <= COL_W'(1);
            ilv_q     <= cfg.interleave && !start_page;
            cl_q      <= cfg.cas_lat;
            col_addr  <= start_col;
            col_valid <= 1'b1;
            col_write <= cmd_write;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    col_valid <= 1'b0;
                end
                ST_BURST, ST_PAGE: begin
                    if (burst_stop) begin
                        col_valid <= 1'b0;
                    end else begin
                        col_addr  <= step_addr;
                        col_valid <= 1'b1;
                        cnt_q     <= cnt_q + COL_W'(1);
                    end
                end
                default: begin
                    col_valid <= 1'b0;
                end
            endcase
        end
    end

    p_busy_has_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> col_valid);

    p_start_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && (col_addr == $past(start_col))));

    p_block_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BURST) && !cmd_start && !burst_stop) |=>
            (col_valid && ((col_addr & ~$past(mask_q)) == ($past(base_q) & ~$past(mask_q)))));

    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && burst_stop && !cmd_start) |=> (!col_valid && !busy));

    p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_start) |=> (!busy && !col_valid));

    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_write && cfg.wr_single) |=> (!busy && col_write && col_valid));

endmodule

// File: tb/tb_sdram_col_seq.sv
`timescale 1ns/100ps
module tb_sdram_col_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_load;
    logic [12:0] mode_word;
    logic        cmd_start;
    logic        cmd_write;
    logic [7:0]  start_col;
    logic        burst_stop;
    logic [7:0]  col_addr;
    logic        col_valid;
    logic        col_write;
    logic        busy;
    logic        rd_valid;
    logic        mode_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #2.5 clk = ~clk;

    sdram_col_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_load  (mode_load),
        .mode_word  (mode_word),
        .cmd_start  (cmd_start),
        .cmd_write  (cmd_write),
        .start_col  (start_col),
        .burst_stop (burst_stop),
        .col_addr   (col_addr),
        .col_valid  (col_valid),
        .col_write  (col_write),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .mode_err   (mode_err)
    );

    // behavioural reference model
    int m_len, m_cl;
    bit m_page, m_ilv, m_wb, m_err;
    int e_base, e_n, e_len, e_cl, e_addr, cyc;
    bit e_page, e_ilv, e_wr, e_valid, e_active, e_rdv;
    bit [7:0] sched;

    function automatic int calc_addr(int base, int n, int len, bit ilv);
        int low;
        low = base % len;
        if (ilv) low = low ^ n;
        else     low = (low + n) % len;
        return base - (base % len) + low;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 1; m_cl = 2; m_page = 0; m_ilv = 0; m_wb = 0; m_err = 0;
            e_valid = 0; e_active = 0; e_rdv = 0; e_wr = 0; e_cl = 2;
            e_base = 0; e_n = 0; e_len = 1; e_page = 0; e_ilv = 0; e_addr = 0;
            sched = '0; cyc = 0;
        end else begin
            bit was_active;
            cyc++;
            was_active = e_active;
            if (e_valid && !e_wr) sched[(cyc - 1 + e_cl) % 8] = 1'b1;
            if (cmd_start) begin
                bit single;
                single   = cmd_write && m_wb;
                e_base   = int'(start_col);
                e_n      = 0;
                e_page   = m_page && !single;
                e_len    = single ? 1 : m_len;
                e_ilv    = m_ilv;
                e_wr     = cmd_write;
                e_cl     = m_cl;
                e_valid  = 1;
                e_addr   = int'(start_col);
                e_active = e_page || (e_len > 1);
            end else if (e_active && burst_stop) begin
                e_active = 0;
                e_valid  = 0;
            end else if (e_active) begin
                e_n++;
                e_addr  = calc_addr(e_base, e_n, e_len, e_ilv);
                e_valid = 1;
                if (!e_page && e_n == e_len - 1) e_active = 0;
            end else begin
                e_valid = 0;
            end
            if (mode_load) begin
                int lc, cl;
                bit ok;
                lc = int'(mode_word[2:0]);
                cl = int'(mode_word[6:4]);
                ok = ((lc <= 3) || (lc == 7 && !mode_word[3])) && (cl == 2 || cl == 3)
                     && (mode_word[8:7] == 2'b00) && !was_active;
                if (ok) begin
                    m_page = (lc == 7);
                    m_len  = (lc == 7) ? 256 : (1 << lc);
                    m_ilv  = mode_word[3];
                    m_cl   = cl;
                    m_wb   = mode_word[9];
                end else begin
                    m_err = 1;
                end
            end
            e_rdv = sched[cyc % 8];
            sched[cyc % 8] = 1'b0;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("col_valid", int'(col_valid), int'(e_valid));
            chk("busy", int'(busy), int'(e_active));
            chk("rd_valid", int'(rd_valid), int'(e_rdv));
            chk("mode_err", int'(mode_err), int'(m_err));
            if (e_valid) begin
                chk("col_addr", int'(col_addr), e_addr);
                chk("col_write", int'(col_write), int'(e_wr));
            end
        end
    end

    function automatic logic [12:0] mk(input int len, input int bt, input int cl,
                                       input int op, input int wb, input int rsv);
        return {3'(rsv), 1'(wb), 2'(op), 3'(cl), 1'(bt), 3'(len)};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [12:0] w);
        mode_load = 1'b1; mode_word = w;
        tick(1);
        mode_load = 1'b0; mode_word = '0;
    endtask

    task automatic start(input bit wr, input logic [7:0] col);
        cmd_start = 1'b1; cmd_write = wr; start_col = col;
        tick(1);
        cmd_start = 1'b0; cmd_write = 1'b0;
    endtask

    task automatic stop();
        burst_stop = 1'b1;
        tick(1);
        burst_stop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; cmd_start = 1'b0;
        cmd_write = 1'b0; start_col = '0; burst_stop = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        cur_req = "R1";                       // default mode: one address, CL2
        start(0, 8'h05); tick(5);

        cur_req = "R4";                       // length 4 sequential, wraps in block
        load(mk(2, 0, 2, 0, 0, 0));
        start(0, 8'h1E); tick(7);
        start(0, 8'h33); tick(6);

        cur_req = "R5";                       // length 8 interleaved, CL3
        load(mk(3, 1, 3, 0, 0, 0));
        start(0, 8'h45); tick(11);

        cur_req = "R6";                       // length 2 sequential, odd start
        load(mk(1, 0, 3, 0, 0, 0));
        start(0, 8'h33); tick(5);
        start(1, 8'h80); tick(4);

        cur_req = "R7";                       // full page wraps, stops on terminate
        load(mk(7, 0, 2, 0, 0, 0));
        start(0, 8'hFC); tick(8);
        stop(); tick(4);
        start(1, 8'h10); tick(2);
        stop(); tick(3);

        cur_req = "R8";                       // single-location writes
        load(mk(3, 0, 2, 0, 1, 0));
        start(1, 8'h17); tick(3);
        start(0, 8'h17); tick(12);

        cur_req = "R9";                       // truncation by a new start
        load(mk(3, 0, 2, 0, 0, 0));
        start(0, 8'h20); tick(2);
        start(1, 8'h47); tick(10);

        cur_req = "R10";                      // read then write, CL3 timing
        load(mk(2, 0, 3, 0, 0, 0));
        start(0, 8'h00); tick(1);
        start(1, 8'h08); tick(8);

        cur_req = "R11";                      // idle stop, start+stop, load+start
        stop(); tick(2);
        burst_stop = 1'b1; start(0, 8'h61); burst_stop = 1'b0; tick(8);
        mode_load = 1'b1; mode_word = mk(0, 0, 2, 0, 0, 0);
        start(0, 8'h70);
        mode_load = 1'b0; mode_word = '0;
        tick(6);
        start(0, 8'h70); tick(4);

        cur_req = "R3";                       // illegal loads keep the mode
        load(mk(2, 0, 3, 0, 0, 0));
        load(mk(4, 0, 2, 0, 0, 0));
        load(mk(7, 1, 2, 0, 0, 0));
        load(mk(2, 0, 1, 0, 0, 0));
        load(mk(2, 0, 4, 0, 0, 0));
        load(mk(2, 0, 2, 1, 0, 0));
        start(0, 8'h2D); tick(1);
        load(mk(1, 0, 2, 0, 0, 0));
        tick(8);
        load(mk(1, 0, 2, 0, 0, 0));
        start(0, 8'h2D); tick(5);

        cur_req = "R2";                       // reserved upper bits have no effect
        load(mk(2, 1, 3, 0, 0, 5));
        start(0, 8'h0B); tick(8);

        tick(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule